// File: doc/BRIEF.md
# Run-Time Configurable GF(2^8) Column Mixer

This block performs the column-mixing step of an AES-style block cipher, with the field arithmetic chosen at run time rather than fixed in hardware. A 32-bit column of four bytes is multiplied by a circulant matrix. The first row of that matrix is a four-byte coefficient word supplied by the caller. All byte products are reduced modulo a 9-bit irreducible polynomial, which is also an input. The result is registered and appears one clock after the column is accepted. A new column can be accepted on every cycle.

The block holds two coefficient banks, one for the forward (encrypt) direction and one for the inverse (decrypt) direction. A load pulse captures a polynomial and a coefficient row into the bank named by the direction select. Over eight cycles, the block then fills that bank with the seven successive doublings (xtime) of each coefficient under the captured polynomial. Once a bank is filled, every data cycle needs only AND/XOR selection over these stored powers. The same network serves both directions, and the direction select only picks which bank feeds it. The caller supplies the inverse coefficient row for decryption; the block does not derive it.

Top module: `gf_column_mixer`

## Requirements
- R1: While reset is active and directly after it, `busy` and `out_valid` are low and `out_col` is zero.
- R2: A `param_load` pulse while `busy` is low captures `poly` and `coef` into the bank named by `dir` (0 = forward bank, 1 = inverse bank). `busy` then goes high on the next cycle and stays high for exactly 8 cycles.
- R3: A column accepted when `in_valid` is high and `busy` is low gives `out_valid` high on the next cycle. Output byte i is the XOR over j of coef[(j-i) mod 4] times in byte j, with products in GF(2^8) reduced by the low byte of the bank's polynomial. Byte 0 is bits [31:24] of `in_col`, `coef` and `out_col`, and byte 3 is bits [7:0].
- R4: With polynomial 0x11B and row 0x02030101 in the forward bank, column 0xdb135345 maps to 0x8e4da1bc, and 0xf20a225c maps to 0x9fdc589d.
- R5: The `dir` value during a data cycle selects the bank used. With row 0x0e0b0d09 and polynomial 0x11B in the inverse bank, 0x8e4da1bc maps back to 0xdb135345.
- R6: `in_valid` while `busy` is high is ignored: `out_valid` stays low on the next cycle and `out_col` keeps its value.
- R7: A `param_load` pulse while `busy` is high is ignored. The bank keeps the contents of the load already in progress.
- R8: Columns presented on consecutive cycles each produce a correct output one cycle later, even when `dir` changes from cycle to cycle.
- R9: Changes on `poly` and `coef` outside an accepted load have no effect. Loading one bank leaves the other bank unchanged.
- R10: A column accepted in the same cycle as an accepted load uses the contents that bank held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| param_load | input | 1 | Start a bank load from `poly` and `coef` |
| dir | input | 1 | Bank select: 0 forward, 1 inverse; used for loads and data |
| poly | input | 9 | Irreducible polynomial; bit 8 is the x^8 term |
| coef | input | 32 | Circulant row, byte 0 in bits [31:24] |
| in_valid | input | 1 | Column present on `in_col` |
| in_col | input | 32 | Input column, byte 0 in bits [31:24] |
| busy | output | 1 | Bank load in progress |
| out_valid | output | 1 | `out_col` holds a new result |
| out_col | output | 32 | Mixed column |

## Verification
The bench checks the timing of the load window. If `busy` is off by one cycle, the load runs past the bench's count or stops short. If the table fill does not finish, the first column after the load comes out with the highest coefficient powers still at zero. Columns, and a second load pulse, are pushed into the busy window; a design that accepted either would raise `out_valid`, change `out_col` or switch to the wrong coefficient row. The bench alternates `dir` while streaming columns back to back, and it loads a non-standard polynomial. A design that read the wrong bank, reduced with a fixed modulus or mis-ordered the circulant bytes would then disagree with the bench's bit-serial GF model. A column issued together with a load must use the old row; it exposes a design that lets the new row reach the datapath too early.

// File: rtl/gf_column_mixer.sv
module gf_column_mixer #(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 param_load,
  input  logic                 dir,
  input  logic [8:0]           poly,
  input  logic [LANES*8-1:0]   coef,
  input  logic                 in_valid,
  input  logic [LANES*8-1:0]   in_col,
  output logic                 busy,
  output logic                 out_valid,
  output logic [LANES*8-1:0]   out_col
);
  localparam int W    = 8;
  localparam int COLW = LANES * W;
  localparam int LW   = $clog2(LANES);

  logic [W-1:0]   tbl [2][LANES][W];
  logic [W-1:0]   cur [LANES];
  logic [W-1:0]   red_r;
  logic [2:0]     step;
  logic           tgt;
  logic [COLW-1:0] mix;

  wire take_load = param_load && !busy;
  wire take_data = in_valid && !busy;

  function automatic logic [W-1:0] xt(input logic [W-1:0] a, input logic [W-1:0] m);
    return {a[W-2:0], 1'b0} ^ (a[W-1] ? m : '0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      step  <= '0;
      tgt   <= 1'b0;
      red_r <= '0;
      for (int k = 0; k < LANES; k++) begin
        cur[k] <= '0;
        for (int b = 0; b < 2; b++)
          for (int p = 0; p < W; p++)
            tbl[b][k][p] <= '0;
      end
    end else if (take_load) begin
      busy  <= 1'b1;
      step  <= '0;
      tgt   <= dir;
      red_r <= poly[W-1:0];
      for (int k = 0; k < LANES; k++)
        cur[k] <= coef[COLW-1-W*k -: W];
    end else if (busy) begin
      for (int k = 0; k < LANES; k++) begin
        tbl[tgt][k][step] <= cur[k];
        cur[k] <= xt(cur[k], red_r);
      end
      step <= step + 3'd1;
      if (step == 3'd7) busy <= 1'b0;
    end
  end

  always_comb begin
    mix = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [W-1:0] acc;
      acc = '0;
      for (int j = 0; j < LANES; j++) begin
        logic [LW-1:0] k;
        logic [W-1:0]  bj;
        k  = LW'(j - i);
        bj = in_col[COLW-1-W*j -: W];
        for (int p = 0; p < W; p++)
          if (bj[p]) acc = acc ^ tbl[dir][k][p];
      end
      mix[COLW-1-W*i -: W] = acc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_col   <= '0;
    end else begin
      out_valid <= take_data;
      if (take_data) out_col <= mix;
    end
  end

  logic [3:0] chk_run;
  always_ff @(posedge clk) begin
    if (!rst_n)    chk_run <= '0;
    else if (busy) chk_run <= chk_run + 4'd1;
    else           chk_run <= '0;
  end

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (param_load && !busy) |=> busy);
  assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (chk_run < 4'd8));
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(chk_run) == 4'd7));
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> out_valid);
  assert_ignore_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !out_valid);
  assert_hold_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_col));
endmodule

// File: tb/tb_gf_column_mixer.sv
`timescale 1ns/1ps
module tb_gf_column_mixer;
  logic clk = 0;
  logic rst_n = 0;
  logic param_load = 0, dir = 0, in_valid = 0;
  logic [8:0] poly = '0;
  logic [31:0] coef = '0, in_col = '0;
  logic busy, out_valid;
  logic [31:0] out_col;

  int checks = 0, fails = 0;
  logic [7:0]  sh_red [2];
  logic [31:0] sh_row [2];

  always #2.5 clk = ~clk;

  gf_column_mixer dut (.clk(clk), .rst_n(rst_n), .param_load(param_load), .dir(dir),
    .poly(poly), .coef(coef), .in_valid(in_valid), .in_col(in_col),
    .busy(busy), .out_valid(out_valid), .out_col(out_col));

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int p = 0; p < 8; p++) begin
      if (b[p]) r ^= x;
      x = x[7] ? ((x << 1) ^ m) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] row, input logic [7:0] m);
    logic [31:0] o = 0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] acc = 0;
      for (int j = 0; j < 4; j++)
        acc ^= gmul(row[31-8*((j-i+4)%4) -: 8], c[31-8*j -: 8], m);
      o[31-8*i -: 8] = acc;
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input bit b, input logic [8:0] p, input logic [31:0] row);
    int n;
    @(negedge clk);
    param_load = 1; dir = b; poly = p; coef = row; in_valid = 0;
    @(posedge clk); #1;
    n = busy ? 1 : 0;
    @(negedge clk); param_load = 0;
    while (busy && n < 20) begin
      @(posedge clk); #1;
      if (busy) n++;
    end
    check(n == 8, "R2 busy length", 32'(n), 32'd8);
    sh_red[b] = p[7:0]; sh_row[b] = row;
  endtask

  task automatic send(input bit b, input logic [31:0] c, input string tag);
    logic [31:0] e;
    @(negedge clk);
    in_valid = 1; dir = b; in_col = c;
    e = model(c, sh_row[b], sh_red[b]);
    @(posedge clk); #1;
    check(out_valid === 1'b1, {tag, " valid"}, 32'(out_valid), 32'd1);
    check(out_col === e, tag, out_col, e);
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 0;
  endtask

  task automatic t_reset();
    check(busy === 0 && out_valid === 0, "R1 flags", {30'd0, busy, out_valid}, 32'd0);
    check(out_col === 32'd0, "R1 out_col", out_col, 32'd0);
  endtask

  task automatic t_aes();
    load(0, 9'h11B, 32'h02030101);
    send(0, 32'hdb135345, "R4 vec1");
    check(out_col === 32'h8e4da1bc, "R4 literal1", out_col, 32'h8e4da1bc);
    send(0, 32'hf20a225c, "R4 vec2");
    check(out_col === 32'h9fdc589d, "R4 literal2", out_col, 32'h9fdc589d);
    idle();
  endtask

  task automatic t_inverse();
    load(1, 9'h11B, 32'h0e0b0d09);
    send(1, 32'h8e4da1bc, "R5 inverse");
    check(out_col === 32'hdb135345, "R5 literal", out_col, 32'hdb135345);
    send(0, 32'hdb135345, "R9 forward bank kept");
    idle();
  endtask

  task automatic t_custom();
    logic [31:0] c = 32'h1234abcd;
    load(0, 9'h11D, 32'h571fa306);
    for (int i = 0; i < 6; i++) begin
      poly = 9'h1F5; coef = c ^ 32'hffff0000;
      send(0, c, "R3 custom poly R9 bus noise");
      c = {c[30:0], c[31] ^ c[21] ^ c[1] ^ c[0]} + 32'h9e3779b9;
    end
    idle();
  endtask

  task automatic t_busy_ignore();
    logic [31:0] held;
    @(negedge clk);
    param_load = 1; dir = 0; poly = 9'h11B; coef = 32'h02030101;
    @(posedge clk); #1;
    held = out_col;
    @(negedge clk);
    coef = 32'h0e0b0d09; in_valid = 1; in_col = 32'hcafef00d;
    for (int n = 1; n <= 8; n++) begin
      @(posedge clk); #1;
      check(out_valid === 1'b0, "R6 no valid while busy", 32'(out_valid), 32'd0);
      check(out_col === held, "R6 out_col held", out_col, held);
    end
    check(busy === 1'b0, "R2 busy ended", 32'(busy), 32'd0);
    @(negedge clk); param_load = 0; in_valid = 0;
    sh_red[0] = 8'h1B; sh_row[0] = 32'h02030101;
    send(0, 32'hdb135345, "R7 second load ignored");
    idle();
  endtask

  task automatic t_stream();
    logic [31:0] c = 32'h0badc0de;
    for (int i = 0; i < 16; i++) begin
      send(i[0], c, "R8 back-to-back");
      c = c * 32'd1103515245 + 32'd12345;
    end
    idle();
  endtask

  task automatic t_same_cycle();
    logic [31:0] e;
    @(negedge clk);
    param_load = 1; dir = 0; poly = 9'h11B; coef = 32'h03010102;
    in_valid = 1; in_col = 32'h01020304;
    e = model(32'h01020304, sh_row[0], sh_red[0]);
    @(posedge clk); #1;
    check(out_valid === 1'b1 && out_col === e, "R10 old bank used", out_col, e);
    @(negedge clk); param_load = 0; in_valid = 0;
    while (busy) @(posedge clk);
    sh_row[0] = 32'h03010102; sh_red[0] = 8'h1B;
    send(0, 32'h01020304, "R10 new bank after load");
    idle();
  endtask

  initial begin
    sh_red[0] = 0; sh_red[1] = 0; sh_row[0] = 0; sh_row[1] = 0;
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1; t_reset();
    t_aes();
    t_inverse();
    t_custom();
    t_busy_ignore();
    t_stream();
    t_same_cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule